// File: doc/BRIEF.md
# Fixed-Priority Maskable Interrupt Controller

This block collects eleven maskable interrupt sources and turns them into a single request towards a CPU core. Four of the sources are external pins. Each pin passes through a synchronizer and is then detected either on an edge of a chosen polarity or, in level mode, while it sits at its active level. The other seven sources are one-cycle event pulses: four timer compare matches, an interval-timer overflow, an ADC conversion-done and a watchdog match. Each pulse sets a request flag.

Software reaches the request flags, the per-source enable flags and the external-input configuration over a byte-wide read/write bus. The master enable comes in as a separate input from the CPU status word. The block registers a request line and a 4-bit vector index that names the highest-priority source that is both pending and enabled. When the core returns a one-cycle acknowledge, the flag of the acknowledged source is cleared. An external source in level mode is the exception and keeps its flag.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` and `vec_idx` are 0. All request and enable flags read 0, and the external configuration register reads 0xF0 (all four inputs edge-triggered on the falling edge).
- R2: Register map. Request-high is at 0xF7 and holds, from bit 7 down to bit 0, the flags of INT0, INT1, INT2, INT3, T0, T1, T2 and T3. Request-low is at 0xF5 and holds ADC in bit 7, WDT in bit 6 and BIT in bit 5; its bits 4..0 always read 0. Enable-high (0xF6) and enable-low (0xF4) use the same bit positions. The configuration register at 0xF3 holds the polarity of INTn in bit n (1 = rising or active-high) and the mode of INTn in bit n+4 (1 = edge). Read data appears on the clock edge after the address.
- R3: In edge mode, an external input sets its flag on the selected transition only. The opposite transition leaves the flag unchanged.
- R4: A one-cycle pulse on `tmr_match[k]`, `adc_done`, `ivt_ovf` or `wdt_match` sets the flag of T(k), ADC, BIT or WDT.
- R5: A source can raise `irq_req` only when its flag, its enable flag and `master_en` are all 1. With no such source, `irq_req` is 0.
- R6: `vec_idx` gives the winning source with the fixed encoding INT0=0, INT1=1, INT2=2, INT3=3, T0..T3=4..7, ADC=8, BIT=9, WDT=10. A lower index always wins.
- R7: A one-cycle `ack` while `irq_req` is 1 clears the flag of the source named by `vec_idx`. This applies to every internal source and to external sources in edge mode. Request and index then move to the next pending source on the following edge.
- R8: In level mode, an external flag is set in every cycle its synchronized input is at the active level. Neither `ack` nor a software write of 0 clears it while that level persists.
- R9: When a hardware set event and a software write of 0 hit the same flag in the same cycle, the flag ends up 1.
- R10: Software writes to the request registers set and clear flags directly, and a flag set this way raises a request like a hardware event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rd_data | output | 8 | Registered read data |
| ext_pin | input | 4 | External interrupt inputs INT0..INT3 (asynchronous) |
| tmr_match | input | 4 | Timer 0..3 compare-match pulses |
| ivt_ovf | input | 1 | Interval-timer overflow pulse |
| adc_done | input | 1 | ADC conversion-complete pulse |
| wdt_match | input | 1 | Watchdog match pulse |
| master_en | input | 1 | Master interrupt enable from the CPU status word |
| ack | input | 1 | One-cycle acknowledge from the CPU |
| irq_req | output | 1 | Registered interrupt request |
| vec_idx | output | 4 | Registered index of the winning source |

## Verification
The hardest situation to reach from the ports is a hardware set event landing in the same cycle as a software clear or an acknowledge, because both must fall on one clock edge. The stimulus places the bus write and the event pulse on the same falling edge. The other hard case is a level-mode external input that must survive both an acknowledge and a software clear. For that, the pin is held at its active level while those operations are issued, then released, and the clear is issued again. Constrained-random enable and flag patterns, with the master enable varied, cover the priority ordering beyond the directed cases.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int N_EXT   = 4;
  localparam int N_TMR   = 4;
  localparam int N_SRC   = N_EXT + N_TMR + 3;
  localparam int IDX_W   = $clog2(N_SRC);
  localparam int SRC_ADC = N_EXT + N_TMR;
  localparam int SRC_BIT = SRC_ADC + 1;
  localparam int SRC_WDT = SRC_ADC + 2;

  // Source lives in the high request/enable byte
  function automatic bit in_hi_byte(input int s);
    return s < (N_EXT + N_TMR);
  endfunction

  // Bit position of a source within its byte
  function automatic int byte_pos(input int s);
    if (s < (N_EXT + N_TMR)) return 7 - s;
    else if (s == SRC_ADC)   return 7;
    else if (s == SRC_WDT)   return 6;
    else                     return 5;
  endfunction
endpackage

// File: rtl/pirq_edge_sync.sv
module pirq_edge_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] edge_mode,
  output logic [N-1:0] evt
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [STAGES-1:0] sh;
    logic              prev;
    logic              s;
    assign s = sh[STAGES-1];
    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[STAGES-2:0], pin[g]};
        prev <= s;
      end
    end
    always_comb begin
      if (edge_mode[g])
        evt[g] = pol[g] ? (s & ~prev) : (~s & prev);
      else
        evt[g] = (s == pol[g]);
    end
  end
endmodule

// File: rtl/pirq_flag_bank.sv
module pirq_flag_bank #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] sw_we,
  input  logic [N-1:0] sw_val,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] flags_q,
  output logic [N-1:0] flags_d
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      flags_d[i] = flags_q[i];
      if (sw_we[i])   flags_d[i] = sw_val[i];
      if (ack_clr[i]) flags_d[i] = 1'b0;
      if (hw_set[i])  flags_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end
endmodule

// File: rtl/pirq_prio.sv
module pirq_prio #(
  parameter int N     = 11,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     act,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |act;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (act[i]) idx = IDX_W'(i);
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pirq_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                SYNC_STG  = 2,
  parameter logic [ADDR_W-1:0] A_REQ_HI  = 8'hF7,
  parameter logic [ADDR_W-1:0] A_REQ_LO  = 8'hF5,
  parameter logic [ADDR_W-1:0] A_EN_HI   = 8'hF6,
  parameter logic [ADDR_W-1:0] A_EN_LO   = 8'hF4,
  parameter logic [ADDR_W-1:0] A_CFG     = 8'hF3,
  parameter logic [7:0]        CFG_RESET = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rd_data,
  input  logic [N_EXT-1:0]  ext_pin,
  input  logic [N_TMR-1:0]  tmr_match,
  input  logic              ivt_ovf,
  input  logic              adc_done,
  input  logic              wdt_match,
  input  logic              master_en,
  input  logic              ack,
  output logic              irq_req,
  output logic [IDX_W-1:0]  vec_idx
);
  logic [N_SRC-1:0] flags_q, flags_d, hw_set, sw_we, sw_val, ack_clr;
  logic [N_SRC-1:0] en_q, en_d, act_d;
  logic [N_EXT-1:0] ext_evt, cfg_pol, cfg_mode;
  logic [7:0]       cfg_q;
  logic             wr_req_hi, wr_req_lo, wr_en_hi, wr_en_lo, wr_cfg;
  logic             win_any;
  logic [IDX_W-1:0] win_idx;
  logic [7:0]       req_hi_b, req_lo_b, en_hi_b, en_lo_b;

  assign wr_req_hi = bus_we && (bus_addr == A_REQ_HI);
  assign wr_req_lo = bus_we && (bus_addr == A_REQ_LO);
  assign wr_en_hi  = bus_we && (bus_addr == A_EN_HI);
  assign wr_en_lo  = bus_we && (bus_addr == A_EN_LO);
  assign wr_cfg    = bus_we && (bus_addr == A_CFG);

  assign cfg_pol  = cfg_q[N_EXT-1:0];
  assign cfg_mode = cfg_q[2*N_EXT-1:N_EXT];

  // External input conditioning
  pirq_edge_sync #(.N(N_EXT), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_pin), .pol(cfg_pol),
    .edge_mode(cfg_mode), .evt(ext_evt)
  );

  assign hw_set = {wdt_match, ivt_ovf, adc_done, tmr_match, ext_evt};

  // Per-source software access and acknowledge clear
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    localparam bit HI  = in_hi_byte(s);
    localparam int POS = byte_pos(s);
    assign sw_we[s]  = HI ? wr_req_hi : wr_req_lo;
    assign sw_val[s] = bus_wdata[POS];
    assign en_d[s]   = ((HI ? wr_en_hi : wr_en_lo) ? bus_wdata[POS] : en_q[s]);
    if (s < N_EXT) begin : g_ext
      assign ack_clr[s] = ack && irq_req && (vec_idx == IDX_W'(s)) && cfg_mode[s];
    end else begin : g_int
      assign ack_clr[s] = ack && irq_req && (vec_idx == IDX_W'(s));
    end
  end

  pirq_flag_bank #(.N(N_SRC)) u_flags (
    .clk(clk), .rst(rst), .hw_set(hw_set), .sw_we(sw_we), .sw_val(sw_val),
    .ack_clr(ack_clr), .flags_q(flags_q), .flags_d(flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      cfg_q <= CFG_RESET;
    end else begin
      en_q <= en_d;
      if (wr_cfg) cfg_q <= bus_wdata;
    end
  end

  // Arbitration on next-state flags keeps outputs aligned with flag state
  assign act_d = flags_d & en_d;

  pirq_prio #(.N(N_SRC), .IDX_W(IDX_W)) u_prio (
    .act(act_d), .any(win_any), .idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      vec_idx <= '0;
    end else begin
      irq_req <= win_any && master_en;
      vec_idx <= win_any ? win_idx : '0;
    end
  end

  // Byte packing for readback
  always_comb begin
    req_hi_b = '0;
    req_lo_b = '0;
    en_hi_b  = '0;
    en_lo_b  = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (in_hi_byte(s)) begin
        req_hi_b[byte_pos(s)] = flags_q[s];
        en_hi_b[byte_pos(s)]  = en_q[s];
      end else begin
        req_lo_b[byte_pos(s)] = flags_q[s];
        en_lo_b[byte_pos(s)]  = en_q[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rd_data <= '0;
    else begin
      if      (bus_addr == A_REQ_HI) bus_rd_data <= req_hi_b;
      else if (bus_addr == A_REQ_LO) bus_rd_data <= req_lo_b;
      else if (bus_addr == A_EN_HI)  bus_rd_data <= en_hi_b;
      else if (bus_addr == A_EN_LO)  bus_rd_data <= en_lo_b;
      else if (bus_addr == A_CFG)    bus_rd_data <= cfg_q;
      else                           bus_rd_data <= '0;
    end
  end
endmodule

// File: rtl/pirq_checker.sv
module pirq_checker
  import pirq_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] A_REQ_LO = 8'hF5
) (
  input logic              clk,
  input logic              rst,
  input logic              master_en,
  input logic              ack,
  input logic              irq_req,
  input logic [IDX_W-1:0]  vec_idx,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rd_data,
  input logic [N_SRC-1:0]  flags_q,
  input logic [N_SRC-1:0]  en_q,
  input logic [N_SRC-1:0]  hw_set
);
  logic [N_SRC-1:0] act;
  logic [N_SRC-1:0] below;
  assign act = flags_q & en_q;
  always_comb
    for (int i = 0; i < N_SRC; i++) below[i] = (i < int'(vec_idx));

  a_r5_master_gate: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(master_en));

  a_r5_no_source_no_req: assert property (@(posedge clk) disable iff (rst)
    (act == '0) |-> !irq_req);

  a_r6_index_range: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (int'(vec_idx) < N_SRC));

  a_r6_highest_wins: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (((act >> vec_idx) & N_SRC'(1)) != '0) && ((act & below) == '0));

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_req && (int'(vec_idx) >= N_EXT) && (int'(vec_idx) < N_SRC) && !bus_we
     && (((hw_set >> vec_idx) & N_SRC'(1)) == '0))
    |=> (((flags_q >> $past(vec_idx)) & N_SRC'(1)) == '0));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (hw_set != '0) |=> ((flags_q & $past(hw_set)) == $past(hw_set)));

  a_r2_low_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == A_REQ_LO) |-> (bus_rd_data[4:0] == 5'd0));
endmodule

bind prio_irq_ctrl pirq_checker #(.ADDR_W(ADDR_W), .A_REQ_LO(A_REQ_LO)) u_chk (
  .clk(clk), .rst(rst), .master_en(master_en), .ack(ack), .irq_req(irq_req),
  .vec_idx(vec_idx), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rd_data(bus_rd_data), .flags_q(flags_q), .en_q(en_q), .hw_set(hw_set)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] bus_addr, bus_wdata, bus_rd_data;
  logic       bus_we;
  logic [3:0] ext_pin, tmr_match;
  logic       ivt_ovf, adc_done, wdt_match, master_en, ack, irq_req;
  logic [3:0] vec_idx;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rd_data(bus_rd_data), .ext_pin(ext_pin),
    .tmr_match(tmr_match), .ivt_ovf(ivt_ovf), .adc_done(adc_done),
    .wdt_match(wdt_match), .master_en(master_en), .ack(ack),
    .irq_req(irq_req), .vec_idx(vec_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); d = bus_rd_data;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    rd(a, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic chk_out(input bit er, input logic [3:0] ev, input string req);
    chk(irq_req == er, req, irq_req, er);
    if (er) chk(vec_idx == ev, req, vec_idx, ev);
  endtask

  task automatic do_ack;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Bench's own view of the register layout (R2)
  function automatic logic [7:0] hi_byte(input logic [10:0] v);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[7-i] = v[i];
    return b;
  endfunction
  function automatic logic [7:0] lo_byte(input logic [10:0] v);
    return {v[8], v[10], v[9], 5'b0};
  endfunction
  function automatic logic [3:0] exp_vec(input logic [10:0] a);
    for (int i = 0; i < 11; i++) if (a[i]) return 4'(i);
    return 4'd0;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    ext_pin = 4'hF; tmr_match = '0; ivt_ovf = 0; adc_done = 0; wdt_match = 0;
    master_en = 0; ack = 0;
    wait_n(5);
    rst = 1'b0;
    wait_n(4);

    // R1 reset state
    chk_out(1'b0, 4'd0, "R1 outputs");
    chk(vec_idx == 4'd0, "R1 vec", vec_idx, 0);
    rd_chk(8'hF7, 8'h00, "R1 reqH");
    rd_chk(8'hF5, 8'h00, "R1 reqL");
    rd_chk(8'hF6, 8'h00, "R1 enH");
    rd_chk(8'hF4, 8'h00, "R1 enL");
    rd_chk(8'hF3, 8'hF0, "R1 cfg");

    // R10 / R2 software access and layout
    wr(8'hF7, 8'h10);
    rd_chk(8'hF7, 8'h10, "R10 write flag");
    wr(8'hF5, 8'hFF);
    rd_chk(8'hF5, 8'hE0, "R2 low unimplemented bits");
    wr(8'hF7, 8'h00); wr(8'hF5, 8'h00);
    rd_chk(8'hF7, 8'h00, "R10 clear flag");

    // R4 / R6 / R7 event pulses, priority, acknowledge
    master_en = 1'b1;
    wr(8'hF6, 8'hFF); wr(8'hF4, 8'hE0);
    @(negedge clk); tmr_match = 4'b0010; adc_done = 1'b1;
    @(negedge clk); tmr_match = '0; adc_done = 1'b0;
    chk_out(1'b1, 4'd5, "R4 R6 timer1 over adc");
    rd_chk(8'hF7, 8'h04, "R4 T1IF position");
    rd_chk(8'hF5, 8'h80, "R4 ADIF position");
    do_ack;
    chk_out(1'b1, 4'd8, "R7 next is adc");
    do_ack;
    chk_out(1'b0, 4'd0, "R7 all served");
    @(negedge clk); ivt_ovf = 1'b1; wdt_match = 1'b1;
    @(negedge clk); ivt_ovf = 1'b0; wdt_match = 1'b0;
    chk_out(1'b1, 4'd9, "R6 bit over wdt");
    rd_chk(8'hF5, 8'h60, "R4 BIT WDT positions");
    do_ack;
    chk_out(1'b1, 4'd10, "R7 then wdt");
    do_ack;
    chk_out(1'b0, 4'd0, "R7 wdt served");

    // R5 gating
    @(negedge clk); master_en = 1'b0;
    wr(8'hF7, 8'h01);
    chk_out(1'b0, 4'd0, "R5 master off");
    @(negedge clk); master_en = 1'b1;
    @(negedge clk);
    chk_out(1'b1, 4'd7, "R5 master on");
    wr(8'hF6, 8'hFE);
    chk_out(1'b0, 4'd0, "R5 enable off");
    wr(8'hF6, 8'hFF); wr(8'hF7, 8'h00);

    // R3 / R7 external falling edge, ack clears in edge mode
    @(negedge clk); ext_pin[3] = 1'b0;
    wait_n(4);
    chk_out(1'b1, 4'd3, "R3 falling edge INT3");
    ext_pin[3] = 1'b1;
    do_ack;
    wait_n(4);
    chk_out(1'b0, 4'd0, "R7 edge ack clear");
    rd_chk(8'hF7, 8'h00, "R3 rising ignored INT3");

    // R3 rising polarity on INT1
    wr(8'hF3, 8'hF2);
    @(negedge clk); ext_pin[1] = 1'b0;
    wait_n(4);
    chk_out(1'b0, 4'd0, "R3 falling ignored in rising mode");
    rd_chk(8'hF7, 8'h00, "R3 no INT1 flag");
    @(negedge clk); ext_pin[1] = 1'b1;
    wait_n(4);
    chk_out(1'b1, 4'd1, "R3 rising edge INT1");
    do_ack;
    chk_out(1'b0, 4'd0, "R7 INT1 served");

    // R8 level mode INT2 active-high
    @(negedge clk); ext_pin[2] = 1'b0;
    wr(8'hF3, 8'hB6);
    wait_n(4);
    chk_out(1'b0, 4'd0, "R8 inactive level");
    @(negedge clk); ext_pin[2] = 1'b1;
    wait_n(4);
    chk_out(1'b1, 4'd2, "R8 active level");
    do_ack;
    chk_out(1'b1, 4'd2, "R8 ack does not clear");
    wr(8'hF7, 8'h00);
    rd_chk(8'hF7, 8'h20, "R8 sw clear ignored while active");
    @(negedge clk); ext_pin[2] = 1'b0;
    wait_n(4);
    wr(8'hF7, 8'h00);
    rd_chk(8'hF7, 8'h00, "R8 clear after release");
    chk_out(1'b0, 4'd0, "R8 request gone");
    wr(8'hF3, 8'hF0);
    @(negedge clk); ext_pin[2] = 1'b1;
    wait_n(4);
    chk_out(1'b0, 4'd0, "R3 restore no spurious edge");

    // R9 set beats software clear
    @(negedge clk); bus_addr = 8'hF7; bus_wdata = 8'h00; bus_we = 1'b1; tmr_match = 4'b0001;
    @(negedge clk); bus_we = 1'b0; tmr_match = '0;
    rd_chk(8'hF7, 8'h08, "R9 set wins");
    chk_out(1'b1, 4'd4, "R9 request from T0");
    wr(8'hF7, 8'h00);

    // R5 / R6 constrained random
    for (int it = 0; it < 40; it++) begin
      logic [10:0] en, fl;
      bit m;
      en = 11'($urandom);
      fl = 11'($urandom);
      if (it % 8 == 0) fl = 11'h400;
      m = ($urandom % 4) != 0;
      @(negedge clk); master_en = m;
      wr(8'hF6, hi_byte(en)); wr(8'hF4, lo_byte(en));
      wr(8'hF7, hi_byte(fl)); wr(8'hF5, lo_byte(fl));
      chk_out(m && ((fl & en) != 0), exp_vec(fl & en), "R5 R6 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule